// File: doc/BRIEF.md
# Hypercube Dimension-Order Router Node

This block is the routing stage of one node in a binary hypercube of 2^DIM nodes. Each node carries a fixed DIM-bit label, and two nodes share a link exactly when their labels differ in a single bit. A header holding a destination label arrives on a valid/ready input. The node XORs the destination with its own label. When the result is zero, the header is delivered locally. Otherwise it leaves on the link for the lowest set bit of that difference. The neighbour across link k has the node's label with bit k inverted, so routing always corrects the differing bits from the least significant upward. This gives one minimal path for each source and destination pair.

A single registered holding stage sits between the input and the DIM+1 output ports. Each output port has its own valid and ready. The dimension links are ports 0 to DIM-1 and local delivery is port DIM. The destination label travels with the header unchanged. Alongside it the node reports how many hops remain after the one it has just chosen. The stage accepts a new header in the same cycle the held one drains, so a stream of headers can pass at one per cycle.

Top module: `ecube_router`

## Requirements
- R1: A header whose destination equals the node label is presented on the local port, which is bit DIM of `out_valid`.
- R2: A header whose destination differs from the node label is presented on the link `out_valid[k]`, where k is the index of the least significant set bit of (node label XOR destination).
- R3: At most one bit of `out_valid` is high in any cycle.
- R4: `out_hops` equals the popcount of (node label XOR destination) minus one for a link port, and equals 0 for the local port.
- R5: A header accepted at a clock edge (`in_valid` and `in_ready` high) is presented on its port from that edge onward, with `out_dest` equal to the accepted destination.
- R6: While the selected port's ready is low, `out_valid`, `out_dest` and `out_hops` stay unchanged.
- R7: `in_ready` is high exactly when the holding stage is empty or the selected port's ready is high, so headers can pass back to back at one per cycle.
- R8: After reset, `out_valid` is all zero and `in_ready` is high.
- R9: The ready inputs of ports that are not selected have no effect on a held header.
- R10: DIM must lie in 2..6 and NODE_LABEL must fit in DIM bits, or elaboration fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Incoming header present |
| in_ready | output | 1 | Node can take a header this cycle |
| in_dest | input | DIM | Destination label of the incoming header |
| out_valid | output | DIM+1 | One-hot port strobe: bits 0..DIM-1 are links, bit DIM is local |
| out_ready | input | DIM+1 | Per-port ready from the neighbours and the local sink |
| out_dest | output | DIM | Destination label of the held header |
| out_hops | output | $clog2(DIM+1) | Hops remaining after the chosen hop |

## Verification
Two events can fall in the same cycle: the held header drains through its selected port, and a new header is taken into the same holding stage. The bench provokes this by randomising `in_valid` and all `out_ready` bits every cycle, so that drains, stalls and loads mix freely. It also runs a directed stretch with every ready high and `in_valid` held high. A reference model tracks the single held entry. At each edge it pops the entry on a drain and then pushes a new one on an acceptance. The next cycle's port, label and hop count must match the entry that was pushed, and they must not match the one that was dropped.

// File: rtl/ecube_pkg.sv
package ecube_pkg;
   localparam int unsigned ECUBE_MIN_DIM = 2;
   localparam int unsigned ECUBE_MAX_DIM = 6;

   // Population count over the widest supported label.
   function automatic int unsigned ecube_bits_set(input logic [ECUBE_MAX_DIM-1:0] v);
      int unsigned n;
      n = 0;
      for (int i = 0; i < ECUBE_MAX_DIM; i++) n += {31'd0, v[i]};
      return n;
   endfunction
endpackage

// File: rtl/ecube_port_select.sv
module ecube_port_select #(
   parameter int unsigned DIM = 4,
   parameter int unsigned NODE_LABEL = 5,
   localparam int unsigned HW = $clog2(DIM + 1)
) (
   input  logic [DIM-1:0] dest,
   output logic [DIM:0]   port_sel,
   output logic [HW-1:0]  hops_left
);
   localparam logic [DIM-1:0] SELF = NODE_LABEL[DIM-1:0];

   logic [DIM-1:0] diff;
   logic [DIM-1:0] lowest;
   logic [HW-1:0]  cnt;

   assign diff   = SELF ^ dest;
   assign lowest = diff & (~diff + {{(DIM-1){1'b0}}, 1'b1});

   always_comb begin
      cnt = '0;
      for (int i = 0; i < DIM; i++) cnt = cnt + HW'(diff[i]);
   end

   assign port_sel  = {(diff == '0), lowest};
   assign hops_left = (diff == '0) ? '0 : cnt - HW'(1);

   always_comb begin
      assert_sel_onehot_R3: assert (dest === 'x || $onehot(port_sel));
   end
endmodule

// File: rtl/ecube_hold_stage.sv
module ecube_hold_stage #(
   parameter int unsigned DIM = 4,
   localparam int unsigned HW = $clog2(DIM + 1)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           in_valid,
   output logic           in_ready,
   input  logic [DIM-1:0] in_dest,
   input  logic [DIM:0]   in_port,
   input  logic [HW-1:0]  in_hops,
   output logic [DIM:0]   out_valid,
   input  logic [DIM:0]   out_ready,
   output logic [DIM-1:0] out_dest,
   output logic [HW-1:0]  out_hops
);
   logic           full_q;
   logic [DIM:0]   port_q;
   logic [DIM-1:0] dest_q;
   logic [HW-1:0]  hops_q;
   logic           drain, load;

   assign drain    = full_q && |(port_q & out_ready);
   assign in_ready = !full_q || drain;
   assign load     = in_valid && in_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full_q <= 1'b0;
         port_q <= '0;
         dest_q <= '0;
         hops_q <= '0;
      end else if (load) begin
         full_q <= 1'b1;
         port_q <= in_port;
         dest_q <= in_dest;
         hops_q <= in_hops;
      end else if (drain) begin
         full_q <= 1'b0;
      end
   end

   assign out_valid = full_q ? port_q : '0;
   assign out_dest  = dest_q;
   assign out_hops  = hops_q;

   assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (|out_valid && !(|(out_valid & out_ready))) |=>
         ($stable(out_valid) && $stable(out_dest) && $stable(out_hops)));
   assert_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(out_valid));
   assert_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> (|out_valid && out_dest == $past(in_dest)));
   assert_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(|out_valid) |-> in_ready);
endmodule

// File: rtl/ecube_router.sv
module ecube_router #(
   parameter int unsigned DIM = 4,
   parameter int unsigned NODE_LABEL = 5,
   localparam int unsigned HW = $clog2(DIM + 1)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           in_valid,
   output logic           in_ready,
   input  logic [DIM-1:0] in_dest,
   output logic [DIM:0]   out_valid,
   input  logic [DIM:0]   out_ready,
   output logic [DIM-1:0] out_dest,
   output logic [HW-1:0]  out_hops
);
   import ecube_pkg::*;

   localparam logic [DIM-1:0] SELF = NODE_LABEL[DIM-1:0];

   // R10: elaboration-time parameter checks
   if (DIM < ECUBE_MIN_DIM || DIM > ECUBE_MAX_DIM) begin : g_bad_dim
      $error("ecube_router: DIM out of range");
   end
   if (NODE_LABEL >= (1 << DIM)) begin : g_bad_label
      $error("ecube_router: NODE_LABEL does not fit in DIM bits");
   end

   logic [DIM:0]  sel_port;
   logic [HW-1:0] sel_hops;

   ecube_port_select #(.DIM(DIM), .NODE_LABEL(NODE_LABEL)) u_select (
      .dest      (in_dest),
      .port_sel  (sel_port),
      .hops_left (sel_hops)
   );

   ecube_hold_stage #(.DIM(DIM)) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .in_dest   (in_dest),
      .in_port   (sel_port),
      .in_hops   (sel_hops),
      .out_valid (out_valid),
      .out_ready (out_ready),
      .out_dest  (out_dest),
      .out_hops  (out_hops)
   );

   assert_local_R1: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[DIM] |-> (out_dest == SELF));

   for (genvar k = 0; k < DIM; k++) begin : g_link_chk
      // The neighbour across link k differs in bit k, and all lower bits already agree.
      assert_link_R2: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid[k] |-> (out_dest[k] != SELF[k] &&
            ((out_dest ^ SELF) & ((DIM)'(1 << k) - (DIM)'(1))) == '0));
      assert_hops_R4: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid[k] |->
            (int'(out_hops) + 1 == int'(ecube_bits_set(ECUBE_MAX_DIM'(out_dest ^ SELF)))));
   end

   assert_local_hops_R4: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[DIM] |-> (out_hops == '0));
endmodule

// File: tb/test_ecube_router.sv
module test_ecube_router;
   localparam int unsigned DIM = 4;
   localparam int unsigned NODE_LABEL = 5;
   localparam int unsigned HW = $clog2(DIM + 1);
   localparam time CLK_PERIOD = 10ns;
   localparam logic [DIM-1:0] SELF = NODE_LABEL[DIM-1:0];

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           in_valid = 1'b0;
   logic           in_ready;
   logic [DIM-1:0] in_dest = '0;
   logic [DIM:0]   out_valid;
   logic [DIM:0]   out_ready = '0;
   logic [DIM-1:0] out_dest;
   logic [HW-1:0]  out_hops;

   int checks = 0;
   int fails  = 0;

   // bench model of the single held entry
   logic           m_v = 1'b0;
   logic [DIM-1:0] m_dest = '0;
   logic           prev_stall = 1'b0;
   logic [DIM-1:0] prev_dest = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ecube_router #(.DIM(DIM), .NODE_LABEL(NODE_LABEL)) i_ecube_router (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_dest(in_dest), .out_valid(out_valid), .out_ready(out_ready),
      .out_dest(out_dest), .out_hops(out_hops)
   );

   function automatic int exp_port(input logic [DIM-1:0] d);
      logic [DIM-1:0] x;
      x = d ^ SELF;
      if (x == '0) return DIM;
      for (int i = 0; i < DIM; i++) if (x[i]) return i;
      return DIM;
   endfunction

   function automatic int exp_hops(input logic [DIM-1:0] d);
      int n;
      n = 0;
      for (int i = 0; i < DIM; i++) n += int'((d[i] ^ SELF[i]));
      return (n == 0) ? 0 : n - 1;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // One cycle: check outputs, drive inputs, check in_ready, update the model.
   task automatic step(input logic v, input logic [DIM-1:0] d, input logic [DIM:0] rdy);
      logic [DIM:0] ev;
      bit fin, fout;
      @(negedge clk);
      ev = '0;
      if (m_v) ev[exp_port(m_dest)] = 1'b1;
      check(out_valid == ev, m_v && exp_port(m_dest) == DIM ? "R1" : "R2",
            int'(out_valid), int'(ev));
      check($countones(out_valid) <= 1, "R3", $countones(out_valid), 1);
      if (m_v) begin
         check(out_dest == m_dest, "R5", int'(out_dest), int'(m_dest));
         check(int'(out_hops) == exp_hops(m_dest), "R4", int'(out_hops), exp_hops(m_dest));
      end
      if (prev_stall)
         check(out_dest == prev_dest && |out_valid, "R6", int'(out_dest), int'(prev_dest));
      in_valid  = v;
      in_dest   = d;
      out_ready = rdy;
      #1;
      fout = m_v && rdy[exp_port(m_dest)];
      check(in_ready == (!m_v || fout), "R7", int'(in_ready), int'(!m_v || fout));
      fin = v && in_ready;
      prev_stall = m_v && !fout && !fin;
      prev_dest  = m_dest;
      if (fout) m_v = 1'b0;
      if (fin) begin
         m_v = 1'b1;
         m_dest = d;
      end
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 150000);
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin : main
      int unsigned seed;
      seed = 32'h1F2E3D4C;
      void'($urandom(seed));
      repeat (3) @(negedge clk);
      check(out_valid == '0, "R8", int'(out_valid), 0);
      check(in_ready == 1'b1, "R8", int'(in_ready), 1);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: local delivery
      step(1'b1, SELF, '1);
      // R2/R4: every single-bit neighbour, and the farthest node
      for (int k = 0; k < DIM; k++) step(1'b1, SELF ^ DIM'(1 << k), '1);
      step(1'b1, ~SELF, '1);
      step(1'b0, '0, '1);
      // R9: hold a header for link 1 while every other ready is high
      step(1'b1, SELF ^ DIM'(2), '0);
      for (int c = 0; c < 4; c++) step(1'b1, SELF, ~(DIM+1)'(2));
      step(1'b0, '0, '1);
      // R7: back-to-back stream with every ready high
      for (int c = 0; c < 20; c++) step(1'b1, DIM'($urandom), '1);
      // random mix of loads, drains and stalls
      for (int c = 0; c < 3000; c++)
         step(($urandom % 4) != 0, DIM'($urandom), (DIM+1)'($urandom));
      step(1'b0, '0, '1);
      step(1'b0, '0, '1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule